// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a clocked host port and an external 256K x 16 asynchronous static RAM. The host offers one single-word request at a time (address, write data, a two-bit lane mask and a read/write flag) under a valid/ready handshake. The controller turns each request into a timed sequence on the memory's active-low strobes: chip select, write strobe, output enable and one enable per byte lane. It drives the memory data bus only while it is writing. A read returns the word through a one-cycle response pulse.

Every analogue timing minimum is a picosecond parameter. The controller rounds each one up to a whole number of clock cycles. The defaults assume a 10 ns clock, which gives a two-cycle read, a write of one setup cycle, one strobe cycle and one hold cycle, and a 100-cycle start-up wait.

The control flow is a state machine with seven states. BOOT waits out the power-up delay and then moves to IDLE. IDLE accepts a request. From there a read goes to READ. A write goes to WSET, or it goes to TURN first when the previous access was a read. TURN always moves on to WSET. The write then steps WSET to WPUL to WHLD. WHLD and READ each return to IDLE when their phase count expires.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is low, chip select, write strobe, output enable and both lane enables are high, the bus drivers are off, and req_ready and rsp_valid are low.
- R2: After reset is released, req_ready stays low for exactly 100 clock edges (the power-up time of 1 us rounded up to 10 ns cycles). A request offered during that time causes no strobe activity.
- R3: A request is accepted only on an edge where req_valid and req_ready are both high. req_ready is low in every cycle that an access occupies.
- R4: A write holds chip select low for 1 setup cycle with the bus driven and the write strobe high. It then holds the write strobe low for 1 cycle, then keeps 1 hold cycle with chip select low, the write strobe high and the bus still driven. Output enable stays high throughout, and req_ready returns on the next cycle.
- R5: Mask bit 0 selects the low byte (data bits 7:0) and mask bit 1 selects the high byte (bits 15:8). During an access each lane enable is the inverse of its mask bit, and outside an access both lane enables are high. A lane with mask bit 0 is left unchanged by a write.
- R6: A read holds chip select and output enable low, with the write strobe high, for 2 cycles. It samples the bus on the final edge of that window. rsp_valid is then high for exactly one cycle, with the word on rsp_rdata.
- R7: In a read, each byte of rsp_rdata whose mask bit is 0 is returned as zero. A read with mask 00 returns 0000.
- R8: When a write is accepted straight after a read, one extra cycle passes with all strobes high and the drivers off before write setup begins.
- R9: The data drivers are on only in the three write states, and never in a cycle where output enable is low.
- R10: Read length, write strobe length and hold length are the relevant timing minimums divided by the clock period and rounded up. The whole write spans at least the write-to-float time plus the data setup time.
- R11: The memory address and the driven write data stay constant through every cycle of an access, from acceptance until after the hold cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 0 = low byte, bit 1 = high byte |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_rdata | output | 16 | Read data, unselected bytes zero |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Lane enables, active low, bit 0 = low byte |
| mem_dq_o | output | 16 | Data to the bus pads |
| mem_dq_oe | output | 1 | Bus pad driver enable |
| mem_dq_i | input | 16 | Data from the bus pads |

## Verification
Each strobe changes one cycle after the edge that moves the state machine. A write therefore shows its setup, strobe and hold phases in the first, second and third cycles after acceptance, with req_ready back in the fourth. A read keeps its strobes for the first two cycles after acceptance and raises rsp_valid in the third. For each accepted request, the bench queues the expected strobe, address and data pattern of every later cycle. It pops and compares one entry half a clock after each edge, so the values it reads have settled, and an empty queue means an idle cycle with ready set.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_IDLE,
        ST_TURN,
        ST_WSET,
        ST_WPUL,
        ST_WHLD,
        ST_READ
    } ctl_state_e;

    // Round a time in ps up to whole clock cycles.
    function automatic int cyc_of(input int t_ps, input int clk_ps);
        return (t_ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_boot_wait.sv
module sram_boot_wait #(
    parameter int CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int W = $clog2(CYC + 1);
    localparam logic [W-1:0] LAST = W'(CYC - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    assign done = (cnt_q == LAST);
endmodule

// File: rtl/sram_phase_cnt.sv
module sram_phase_cnt #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sram_lane_mux.sv
module sram_lane_mux #(
    parameter int LANES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lanes_on,
    input  logic [LANES-1:0]   mask,
    input  logic               capture,
    input  logic [LANES*8-1:0] dq_in,
    output logic [LANES-1:0]   be_n,
    output logic [LANES*8-1:0] rdata
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [7:0] byte_q;

        assign be_n[i] = ~(lanes_on & mask[i]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                byte_q <= 8'h00;
            else if (capture)
                byte_q <= mask[i] ? dq_in[i*8 +: 8] : 8'h00;
        end

        assign rdata[i*8 +: 8] = byte_q;
    end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int DATA_W     = 16,
    parameter int CLK_PS     = 10000,
    parameter int T_RC_PS    = 12000,
    parameter int T_AA_PS    = 12000,
    parameter int T_ACE_PS   = 12000,
    parameter int T_DOE_PS   = 6000,
    parameter int T_DBE_PS   = 6000,
    parameter int T_PWE_PS   = 8000,
    parameter int T_SD_PS    = 6000,
    parameter int T_AW_PS    = 8000,
    parameter int T_SCE_PS   = 8000,
    parameter int T_BW_PS    = 8000,
    parameter int T_HZWE_PS  = 6000,
    parameter int T_POWER_PS = 1000000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_mask,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_ce_n,
    output logic                mem_we_n,
    output logic                mem_oe_n,
    output logic [DATA_W/8-1:0] mem_be_n,
    output logic [DATA_W-1:0]   mem_dq_o,
    output logic                mem_dq_oe,
    input  logic [DATA_W-1:0]   mem_dq_i
);
    localparam int LANES    = DATA_W / 8;
    localparam int RD_CYC   = max2(1, max2(max2(cyc_of(T_RC_PS, CLK_PS), cyc_of(T_AA_PS, CLK_PS)),
                                   max2(cyc_of(T_ACE_PS, CLK_PS),
                                   max2(cyc_of(T_DOE_PS, CLK_PS), cyc_of(T_DBE_PS, CLK_PS)))));
    localparam int SET_CYC  = 1;
    localparam int WE_CYC   = max2(1, max2(max2(cyc_of(T_PWE_PS, CLK_PS), cyc_of(T_SD_PS, CLK_PS)),
                                   max2(cyc_of(T_AW_PS, CLK_PS) - SET_CYC,
                                   max2(cyc_of(T_SCE_PS, CLK_PS) - SET_CYC,
                                        cyc_of(T_BW_PS, CLK_PS) - SET_CYC))));
    localparam int HOLD_CYC = max2(1, cyc_of(T_HZWE_PS + T_SD_PS, CLK_PS) - SET_CYC - WE_CYC);
    localparam int BOOT_CYC = max2(1, cyc_of(T_POWER_PS, CLK_PS));
    localparam int CNT_W    = $clog2(max2(max2(RD_CYC, WE_CYC), max2(SET_CYC, HOLD_CYC)) + 1);

    ctl_state_e       state, nxt;
    logic [CNT_W-1:0] cnt;
    int               phase_len;
    logic             phase_last;
    logic             boot_done;
    logic             accept;
    logic             rd_done;
    logic             after_rd;
    logic             lanes_on;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  mask_q;

    sram_boot_wait #(.CYC(BOOT_CYC)) u_boot (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (boot_done)
    );

    sram_phase_cnt #(.W(CNT_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (nxt != state),
        .cnt   (cnt)
    );

    sram_lane_mux #(.LANES(LANES)) u_lanes (
        .clk      (clk),
        .rst_n    (rst_n),
        .lanes_on (lanes_on),
        .mask     (mask_q),
        .capture  (rd_done),
        .dq_in    (mem_dq_i),
        .be_n     (mem_be_n),
        .rdata    (rsp_rdata)
    );

    always_comb begin
        unique case (state)
            ST_WSET: phase_len = SET_CYC;
            ST_WPUL: phase_len = WE_CYC;
            ST_WHLD: phase_len = HOLD_CYC;
            ST_READ: phase_len = RD_CYC;
            default: phase_len = 1;
        endcase
    end

    assign phase_last = (cnt == CNT_W'(phase_len - 1));
    assign accept     = (state == ST_IDLE) && req_valid;
    assign rd_done    = (state == ST_READ) && phase_last;

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_BOOT: if (boot_done) nxt = ST_IDLE;
            ST_IDLE: if (req_valid) nxt = req_write ? (after_rd ? ST_TURN : ST_WSET) : ST_READ;
            ST_TURN: nxt = ST_WSET;
            ST_WSET: if (phase_last) nxt = ST_WPUL;
            ST_WPUL: if (phase_last) nxt = ST_WHLD;
            ST_WHLD: if (phase_last) nxt = ST_IDLE;
            ST_READ: if (phase_last) nxt = ST_IDLE;
            default: nxt = ST_BOOT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_BOOT;
        else
            state <= nxt;
    end

    // Registered strobes, decoded from the coming state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_ce_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
            lanes_on  <= 1'b0;
            req_ready <= 1'b0;
        end else begin
            mem_ce_n  <= !(nxt inside {ST_WSET, ST_WPUL, ST_WHLD, ST_READ});
            mem_we_n  <= (nxt != ST_WPUL);
            mem_oe_n  <= (nxt != ST_READ);
            mem_dq_oe <= (nxt inside {ST_WSET, ST_WPUL, ST_WHLD});
            lanes_on  <= (nxt inside {ST_WSET, ST_WPUL, ST_WHLD, ST_READ});
            req_ready <= (nxt == ST_IDLE);
        end
    end

    // Request capture, turnaround flag, response pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            wdata_q   <= '0;
            mask_q    <= '0;
            after_rd  <= 1'b0;
            rsp_valid <= 1'b0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                mask_q  <= req_mask;
            end
            if (accept && req_write)
                after_rd <= 1'b0;
            else if (rd_done)
                after_rd <= 1'b1;
            rsp_valid <= rd_done;
        end
    end

    assign mem_addr = addr_q;
    assign mem_dq_o = wdata_q;

endmodule

// File: rtl/sram_lane_chk.sv
module sram_lane_chk #(
    parameter int AW = 18,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic          mem_ce_n,
    input logic          mem_we_n,
    input logic          mem_oe_n,
    input logic          mem_dq_oe,
    input logic [DW/8-1:0] mem_be_n,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_dq_o
);
    // R9
    drive_vs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R8
    turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |=> !mem_dq_oe);

    // R4
    we_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(!mem_ce_n) && $past(mem_dq_oe)));

    // R4
    we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe));

    // R11
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !mem_we_n) |=> ($stable(mem_addr) && $stable(mem_dq_o)));

    // R3
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready);

    // R6
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R5
    lane_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (mem_be_n == '1));
endmodule

bind sram_lane_ctrl sram_lane_chk #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe),
    .mem_be_n  (mem_be_n),
    .mem_addr  (mem_addr),
    .mem_dq_o  (mem_dq_o)
);

// File: tb/sim_sram_lane_ctrl.sv
module sim_sram_lane_ctrl;
    // Cycle counts taken from the requirements (R10 defaults)
    localparam int BOOT = 100;
    localparam int RD   = 2;
    localparam int SET  = 1;
    localparam int WEP  = 1;
    localparam int HOLD = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [17:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [1:0]  mem_be_n;
    logic [15:0] mem_dq_o;
    logic [15:0] mem_dq_i = 16'h5A5A;

    sram_lane_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_mask  (req_mask),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .mem_addr  (mem_addr),
        .mem_ce_n  (mem_ce_n),
        .mem_we_n  (mem_we_n),
        .mem_oe_n  (mem_oe_n),
        .mem_be_n  (mem_be_n),
        .mem_dq_o  (mem_dq_o),
        .mem_dq_oe (mem_dq_oe),
        .mem_dq_i  (mem_dq_i)
    );

    // 50 MHz
    always #10ns clk = ~clk;

    int  total = 0;
    int  bad = 0;
    int  edges = 0;
    bit  after_rd = 1'b0;
    bit  finished = 1'b0;

    // Each entry: {ce,we,oe,be_n[1],be_n[0],dq_oe,ready,rsp_valid, addr, data}
    logic [41:0] expq[$];
    logic [15:0] rdq[$];
    logic [15:0] dev_mem [logic [17:0]];
    logic [15:0] ref_mem [logic [17:0]];

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_word(input logic [17:0] a);
        return ref_mem.exists(a) ? ref_mem[a] : 16'h0000;
    endfunction

    function automatic logic [15:0] dev_word(input logic [17:0] a);
        return dev_mem.exists(a) ? dev_mem[a] : 16'h0000;
    endfunction

    task automatic push(input logic [7:0] v, input logic [17:0] a, input logic [15:0] d, input int n);
        for (int i = 0; i < n; i++) expq.push_back({v, a, d});
    endtask

    task automatic do_req(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
        logic [1:0]  bn;
        logic [15:0] w;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        req_mask  = m;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        bn = ~m;
        w  = ref_word(a);
        if (wr) begin
            // R8: turnaround cycle after a read
            if (after_rd) push(8'b1111_1000, a, d, 1);
            // R4 setup, strobe, hold
            push({1'b0, 1'b1, 1'b1, bn, 1'b1, 2'b00}, a, d, SET);
            push({1'b0, 1'b0, 1'b1, bn, 1'b1, 2'b00}, a, d, WEP);
            push({1'b0, 1'b1, 1'b1, bn, 1'b1, 2'b00}, a, d, HOLD);
            if (m[0]) w[7:0]  = d[7:0];
            if (m[1]) w[15:8] = d[15:8];
            ref_mem[a] = w;
            after_rd = 1'b0;
        end else begin
            // R6 read window, then response pulse; R7 masked bytes zero
            push({1'b0, 1'b1, 1'b0, bn, 1'b0, 2'b00}, a, d, RD);
            push(8'b1111_1011, a, d, 1);
            rdq.push_back({m[1] ? w[15:8] : 8'h00, m[0] ? w[7:0] : 8'h00});
            after_rd = 1'b1;
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    always @(posedge clk) if (rst_n) edges++;

    // Memory device model, evaluated half a cycle after each edge
    always @(negedge clk) begin
        logic [15:0] cur;
        cur = dev_word(mem_addr);
        if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
            if (!mem_be_n[0]) cur[7:0]  = mem_dq_o[7:0];
            if (!mem_be_n[1]) cur[15:8] = mem_dq_o[15:8];
            dev_mem[mem_addr] = cur;
        end
        if (!mem_ce_n && !mem_oe_n && mem_we_n)
            mem_dq_i = {mem_be_n[1] ? 8'hA5 : cur[15:8], mem_be_n[0] ? 8'hA5 : cur[7:0]};
        else
            mem_dq_i = 16'h5A5A;
    end

    // Cycle-by-cycle comparison against the queued model
    always @(negedge clk) begin
        logic [41:0] e;
        logic [7:0]  ev;
        logic [7:0]  av;
        logic [15:0] rexp;
        if (rst_n && !finished) begin
            if (expq.size() > 0)
                e = expq.pop_front();
            else
                e = {6'b111110, (edges >= BOOT) ? 1'b1 : 1'b0, 1'b0, 34'h0};
            ev = e[41:34];
            av = {mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe, req_ready, rsp_valid};
            check("R2 R3 R4 R5 R6 R8 R9 strobe vector", {56'h0, av}, {56'h0, ev});
            if (!ev[7]) check("R11 address held", {46'h0, mem_addr}, {46'h0, e[33:16]});
            if (ev[2])  check("R11 write data held", {48'h0, mem_dq_o}, {48'h0, e[15:0]});
            if (ev[0]) begin
                rexp = (rdq.size() > 0) ? rdq.pop_front() : 16'hxxxx;
                check("R6 R7 read data", {48'h0, rsp_rdata}, {48'h0, rexp});
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset strobes", {56'h0, mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe, req_ready, rsp_valid},
              {56'h0, 8'b1111_1000});
        rst_n = 1'b1;

        // R2: request held during the start-up wait is not served
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = 18'h00123;
        req_wdata = 16'hFFFF;
        req_mask  = 2'b11;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        check("R2 start-up length", 64'(edges), 64'(BOOT));
        req_valid = 1'b0;

        do_req(1'b1, 18'h00010, 16'h1234, 2'b11);   // R4 full write
        do_req(1'b0, 18'h00010, 16'h0000, 2'b11);   // R6 full read
        do_req(1'b1, 18'h00010, 16'hABCD, 2'b01);   // R8 turnaround, R5 low lane only
        do_req(1'b0, 18'h00010, 16'h0000, 2'b11);   // R5 expect 12CD
        do_req(1'b0, 18'h00010, 16'h0000, 2'b01);   // R7 expect 00CD
        do_req(1'b0, 18'h00010, 16'h0000, 2'b10);   // R7 expect 1200
        do_req(1'b0, 18'h00010, 16'h0000, 2'b00);   // R7 expect 0000
        do_req(1'b1, 18'h3FFFF, 16'h5678, 2'b10);   // R5 high lane only, top address
        do_req(1'b1, 18'h00020, 16'h9999, 2'b00);   // R5 no lane written
        do_req(1'b1, 18'h00021, 16'hC3C3, 2'b11);   // R3 write after write
        do_req(1'b0, 18'h3FFFF, 16'h0000, 2'b11);   // expect 5600
        do_req(1'b0, 18'h00020, 16'h0000, 2'b11);   // R5 expect 0000
        do_req(1'b0, 18'h00021, 16'h0000, 2'b11);   // R6 read after read
        do_req(1'b1, 18'h00021, 16'h0F0F, 2'b10);   // R8 again
        do_req(1'b0, 18'h00021, 16'h0000, 2'b11);   // expect 0FC3

        repeat (8) @(negedge clk);
        check("R3 model queue drained", 64'(expq.size()), 64'd0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog R3 actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule